// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous serial slave that lets an external host read and write an 8-bit register file inside the chip. The host frames every transaction with an active-low chip select. It then clocks a command byte into the serial data input on rising serial-clock edges, least significant bit first. A read returns the addressed register on the serial data output. A write is followed by eight data bits on the input.

The serial clock, chip select, data input and the edge-select configuration pin are sampled by a faster system clock. The block assumes these inputs have already been brought into that clock domain. Edges of the serial clock are found by comparing each sample with the one before it, so each serial-clock phase must last at least two system clocks. On the core side, a simple bus presents an address with one-cycle read or write strobes. Read data is taken from that bus in the same cycle as the read strobe. The output is split into a data bit and an output enable, so a pad cell can build the three-state pin.

The edge-select input sets which serial-clock edge read data is stable for. The output enable is high only while read data is being returned.

Top module: `serreg_port`

## Requirements
- R1: While chip select is low, the data input is captured on each rising serial-clock edge. The first eight captured bits form the command, least significant bit first: bit 0 = 1 for a read and 0 for a write, bits 1 to 6 are the register address, and bit 7 is reserved and has no effect.
- R2: For a write, the next eight rising edges capture the data byte, LSB first. One system clock after the 16th rising edge, the write strobe is high for exactly one cycle, with the address and data on the register bus. No read strobe occurs during a write.
- R3: If chip select rises before the 16th rising edge of a write, no write strobe is issued and the register keeps its value.
- R4: For a read, the read strobe is high for exactly one cycle, one system clock after the 8th rising edge, with the address on the bus. The register data is captured in that cycle, and the output enable rises in the following cycle.
- R5: With the edge-select input high, read bits 0 to 7 (LSB first) are stable on the output at rising edges 9 to 16.
- R6: With the edge-select input low, read bits 0 to 7 (LSB first) are stable on the output at the falling edges that follow rising edges 8 to 15.
- R7: The output enable is low while chip select is high, and for the whole of any write. When it is low, the data output is 0. It falls one cycle after chip select rises.
- R8: Chip select high clears the bit count. Rising edges after the 16th within one chip-select-low period are ignored, so a new transaction needs chip select to go high and then low again.
- R9: After reset, the output enable, the data output and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, already synchronized |
| cs_n_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data in |
| clke_i | input | 1 | Read-data edge select: 1 = stable at rising edge, 0 = stable at falling edge |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| reg_addr_o | output | 6 | Register address |
| reg_rd_stb_o | output | 1 | One-cycle read strobe |
| reg_rd_data_i | input | 8 | Register read data, valid with the read strobe |
| reg_wr_stb_o | output | 1 | One-cycle write strobe |
| reg_wr_data_o | output | 8 | Register write data |

## Verification
The bench writes all 64 addresses, with the edge select alternating and the reserved bit set on some commands. It then reads every address back under both edge-select settings. A design that launched bits on the wrong edge, or shifted once too often, would return each byte shifted by one bit position.

Writes are cut off after 3, 8, 12 and 15 bits. A design that strobed on a partial frame would corrupt the register, and the readback catches that. Frames that run to 24 bits are also sent. A counter that wrapped instead of saturating would issue a second strobe or take the wrong data.

The output enable is sampled at every serial-clock phase of every transaction. This exposes an enable that rises during a write or during the command phase, or that lingers after deselect.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 8;
    localparam int CMD_W   = ADDR_W + 2;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef logic [CNT_W-1:0] bitcnt_t;

    // command byte after LSB-first shifting: bit 0 = read, then address, then reserved
    typedef struct packed {
        logic              rsvd;
        logic [ADDR_W-1:0] addr;
        logic              is_rd;
    } cmd_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    localparam bitcnt_t CNT_CMD       = bitcnt_t'(CMD_W);
    localparam bitcnt_t CNT_CMD_LAST  = bitcnt_t'(CMD_W - 1);
    localparam bitcnt_t CNT_DATA_LAST = bitcnt_t'(FRAME_W - 1);
    localparam bitcnt_t CNT_FULL      = bitcnt_t'(FRAME_W);
    localparam bitcnt_t CNT_FALL_LO   = bitcnt_t'(CMD_W + 1);
    localparam bitcnt_t CNT_FALL_HI   = bitcnt_t'(FRAME_W - 1);
    localparam bitcnt_t CNT_RISE_HI   = bitcnt_t'(FRAME_W - 2);

    function automatic logic in_window(bitcnt_t v, bitcnt_t lo, bitcnt_t hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/serreg_sclk_edge.sv
module serreg_sclk_edge
    import serreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_i,
    output sclk_evt_t evt_o
);

    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
        end
    end

    assign evt_o.rise = sclk_i & ~sclk_q;
    assign evt_o.fall = ~sclk_i & sclk_q;

endmodule

// File: rtl/serreg_rx_frame.sv
module serreg_rx_frame
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sdi_i,
    input  logic              rise_i,
    output bitcnt_t           cnt_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              is_rd_o,
    output logic              cmd_done_o,
    output logic              wr_done_o,
    output logic [DATA_W-1:0] data_o
);

    bitcnt_t           cnt_q;
    cmd_t              cmd_q;
    logic [DATA_W-1:0] data_q;
    logic              cmd_done_q;
    logic              wr_done_q;
    logic              take_bit;

    assign take_bit = rise_i && (cnt_q != CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            cmd_q      <= '0;
            data_q     <= '0;
            cmd_done_q <= 1'b0;
            wr_done_q  <= 1'b0;
        end else if (cs_n_i) begin
            cnt_q      <= '0;
            cmd_done_q <= 1'b0;
            wr_done_q  <= 1'b0;
        end else begin
            cmd_done_q <= 1'b0;
            wr_done_q  <= 1'b0;
            if (take_bit) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q < CNT_CMD) begin
                    cmd_q <= cmd_t'({sdi_i, cmd_q[CMD_W-1:1]});
                end else begin
                    data_q <= {sdi_i, data_q[DATA_W-1:1]};
                end
                if (cnt_q == CNT_CMD_LAST) begin
                    cmd_done_q <= 1'b1;
                end
                if (cnt_q == CNT_DATA_LAST && !cmd_q.is_rd) begin
                    wr_done_q <= 1'b1;
                end
            end
        end
    end

    assign cnt_o      = cnt_q;
    assign addr_o     = cmd_q.addr;
    assign is_rd_o    = cmd_q.is_rd;
    assign cmd_done_o = cmd_done_q;
    assign wr_done_o  = wr_done_q;
    assign data_o     = data_q;

endmodule

// File: rtl/serreg_tx_shift.sv
module serreg_tx_shift
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              clke_i,
    input  sclk_evt_t         evt_i,
    input  bitcnt_t           cnt_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    output logic              sdo_o,
    output logic              oe_o
);

    logic [DATA_W-1:0] sr_q;
    logic              act_q;
    logic              shift_en;

    // edge select high: advance after falling edges so bits settle for rising edges
    // edge select low: advance after rising edges so bits settle for falling edges
    always_comb begin
        if (clke_i) begin
            shift_en = evt_i.fall && in_window(cnt_i, CNT_FALL_LO, CNT_FALL_HI);
        end else begin
            shift_en = evt_i.rise && in_window(cnt_i, CNT_CMD, CNT_RISE_HI);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            act_q <= 1'b0;
        end else if (cs_n_i) begin
            act_q <= 1'b0;
        end else if (load_i) begin
            sr_q  <= load_data_i;
            act_q <= 1'b1;
        end else if (act_q) begin
            if (shift_en) begin
                sr_q <= sr_q >> 1;
            end
            if (evt_i.rise && cnt_i == CNT_FULL) begin
                act_q <= 1'b0;
            end
        end
    end

    assign sdo_o = act_q & sr_q[0];
    assign oe_o  = act_q;

endmodule

// File: rtl/serreg_port.sv
module serreg_port
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              sdi_i,
    input  logic              clke_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_rd_stb_o,
    input  logic [DATA_W-1:0] reg_rd_data_i,
    output logic              reg_wr_stb_o,
    output logic [DATA_W-1:0] reg_wr_data_o
);

    sclk_evt_t evt;
    bitcnt_t   cnt;
    logic      is_rd;
    logic      cmd_done;
    logic      wr_done;

    serreg_sclk_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .evt_o  (evt)
    );

    serreg_rx_frame u_rx (
        .clk        (clk),
        .rst        (rst),
        .cs_n_i     (cs_n_i),
        .sdi_i      (sdi_i),
        .rise_i     (evt.rise),
        .cnt_o      (cnt),
        .addr_o     (reg_addr_o),
        .is_rd_o    (is_rd),
        .cmd_done_o (cmd_done),
        .wr_done_o  (wr_done),
        .data_o     (reg_wr_data_o)
    );

    assign reg_rd_stb_o = cmd_done & is_rd;
    assign reg_wr_stb_o = wr_done;

    serreg_tx_shift u_tx (
        .clk         (clk),
        .rst         (rst),
        .cs_n_i      (cs_n_i),
        .clke_i      (clke_i),
        .evt_i       (evt),
        .cnt_i       (cnt),
        .load_i      (reg_rd_stb_o),
        .load_data_i (reg_rd_data_i),
        .sdo_o       (sdo_o),
        .oe_o        (sdo_oe_o)
    );

endmodule

// File: rtl/serreg_port_chk.sv
module serreg_port_chk (
    input logic clk,
    input logic rst,
    input logic cs_n_i,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic reg_rd_stb_o,
    input logic reg_wr_stb_o
);

    AST_OE_OFF_AFTER_DESELECT: assert property (@(posedge clk) disable iff (rst) cs_n_i |=> !sdo_oe_o); // R7
    AST_SDO_PARKED_LOW: assert property (@(posedge clk) disable iff (rst) !sdo_oe_o |-> !sdo_o); // R7
    AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (rst) reg_wr_stb_o |-> !sdo_oe_o); // R7
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) reg_wr_stb_o |-> !reg_rd_stb_o); // R2
    AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst) reg_wr_stb_o |=> !reg_wr_stb_o); // R2
    AST_RD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst) reg_rd_stb_o |=> !reg_rd_stb_o); // R4
    AST_OE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst) (reg_rd_stb_o && !cs_n_i) |=> sdo_oe_o); // R4

endmodule

bind serreg_port serreg_port_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_n_i       (cs_n_i),
    .sdo_o        (sdo_o),
    .sdo_oe_o     (sdo_oe_o),
    .reg_rd_stb_o (reg_rd_stb_o),
    .reg_wr_stb_o (reg_wr_stb_o)
);

// File: tb/serreg_port_tb.sv
module serreg_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NREG       = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic       clke = 1'b0;
    logic       sdo;
    logic       sdo_oe;
    logic [5:0] reg_addr;
    logic       rd_stb;
    logic [7:0] rd_data;
    logic       wr_stb;
    logic [7:0] wr_data;

    logic [7:0] regs [NREG];
    logic [7:0] exp_mem [NREG];

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int wr_addr_l = 0;
    int wr_data_l = 0;
    int rd_addr_l = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serreg_port u_dut (
        .clk           (clk),
        .rst           (rst),
        .sclk_i        (sclk),
        .cs_n_i        (cs_n),
        .sdi_i         (sdi),
        .clke_i        (clke),
        .sdo_o         (sdo),
        .sdo_oe_o      (sdo_oe),
        .reg_addr_o    (reg_addr),
        .reg_rd_stb_o  (rd_stb),
        .reg_rd_data_i (rd_data),
        .reg_wr_stb_o  (wr_stb),
        .reg_wr_data_o (wr_data)
    );

    assign rd_data = regs[reg_addr];

    initial begin
        for (int i = 0; i < NREG; i++) begin
            regs[i]    = 8'h00;
            exp_mem[i] = 8'h00;
        end
    end

    // register-file model and strobe monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_stb) begin
                wr_cnt++;
                wr_addr_l = int'(reg_addr);
                wr_data_l = int'(wr_data);
                regs[reg_addr] = wr_data;
            end
            if (rd_stb) begin
                rd_cnt++;
                rd_addr_l = int'(reg_addr);
            end
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + 11) ^ (a << 2));
    endfunction

    // one chip-select framed transaction of nbits serial clocks
    task automatic xfer(input logic [7:0] cmd, input logic [7:0] data, input int nbits,
                        input logic ck, input logic rd_chk, input logic [7:0] expv);
        logic b;
        clke = ck;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i < 8) b = cmd[i];
            else if (i < 16) b = data[i-8];
            else b = i[0];
            sclk = 1'b0;
            sdi  = b;
            repeat (HALF) @(negedge clk);
            if (rd_chk && ck && i >= 8 && i <= 15) begin
                chk(sdo === expv[i-8], "R5", "read bit at rising edge", int'(sdo), int'(expv[i-8]));
                chk(sdo_oe === 1'b1, "R5", "oe during read data", int'(sdo_oe), 1);
            end
            if (i < 7) chk(sdo_oe === 1'b0, "R7", "oe in command phase", int'(sdo_oe), 0);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (rd_chk && !ck && i >= 7 && i <= 14) begin
                chk(sdo === expv[i-7], "R6", "read bit at falling edge", int'(sdo), int'(expv[i-7]));
                chk(sdo_oe === 1'b1, "R6", "oe during read data", int'(sdo_oe), 1);
            end
            if (!cmd[0]) chk(sdo_oe === 1'b0, "R7", "oe during write", int'(sdo_oe), 0);
        end
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sdo_oe === 1'b0, "R7", "oe after deselect", int'(sdo_oe), 0);
        chk(sdo === 1'b0, "R7", "sdo after deselect", int'(sdo), 0);
    endtask

    function automatic logic [7:0] mk_cmd(input logic rd, input int a, input logic rsv);
        return {rsv, 6'(a), rd};
    endfunction

    initial begin
        int w0;
        int r0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sdo_oe === 1'b0, "R9", "oe after reset", int'(sdo_oe), 0);
        chk(sdo === 1'b0, "R9", "sdo after reset", int'(sdo), 0);
        chk(rd_stb === 1'b0 && wr_stb === 1'b0, "R9", "strobes after reset",
            int'(rd_stb) + int'(wr_stb), 0);

        // write every address; reserved bit set on every third (R1)
        for (int a = 0; a < NREG; a++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            xfer(mk_cmd(1'b0, a, (a % 3) == 0), pattern(a), 16, a[0], 1'b0, 8'h00);
            exp_mem[a] = pattern(a);
            chk(wr_cnt == w0 + 1, "R2", "one write strobe", wr_cnt - w0, 1);
            chk(wr_addr_l == a, "R1", "write address", wr_addr_l, a);
            chk(wr_data_l == int'(pattern(a)), "R2", "write data", wr_data_l, int'(pattern(a)));
            chk(rd_cnt == r0, "R2", "no read strobe on write", rd_cnt - r0, 0);
        end

        // read every address under both edge selects
        for (int a = 0; a < NREG; a++) begin
            for (int ck = 0; ck < 2; ck++) begin
                w0 = wr_cnt; r0 = rd_cnt;
                xfer(mk_cmd(1'b1, a, ck == 1), 8'h00, 16, ck[0], 1'b1, exp_mem[a]);
                chk(rd_cnt == r0 + 1, "R4", "one read strobe", rd_cnt - r0, 1);
                chk(rd_addr_l == a, "R4", "read address", rd_addr_l, a);
                chk(wr_cnt == w0, "R4", "no write strobe on read", wr_cnt - w0, 0);
            end
        end

        // truncated writes are dropped (R3)
        begin
            int cuts [4] = '{3, 8, 12, 15};
            foreach (cuts[k]) begin
                w0 = wr_cnt;
                xfer(mk_cmd(1'b0, 5, 1'b0), 8'hA5, cuts[k], 1'b0, 1'b0, 8'h00);
                chk(wr_cnt == w0, "R3", "no strobe on cut write", wr_cnt - w0, 0);
            end
            xfer(mk_cmd(1'b1, 5, 1'b0), 8'h00, 16, 1'b1, 1'b1, exp_mem[5]);
            chk(regs[5] == exp_mem[5], "R3", "register kept after cut writes",
                int'(regs[5]), int'(exp_mem[5]));
        end

        // over-long frames: extra bits ignored (R8)
        w0 = wr_cnt;
        xfer(mk_cmd(1'b0, 9, 1'b0), 8'h3C, 24, 1'b0, 1'b0, 8'h00);
        exp_mem[9] = 8'h3C;
        chk(wr_cnt == w0 + 1, "R8", "single strobe on long write", wr_cnt - w0, 1);
        chk(wr_data_l == 8'h3C, "R8", "long write data", wr_data_l, 8'h3C);
        r0 = rd_cnt;
        xfer(mk_cmd(1'b1, 9, 1'b0), 8'h00, 24, 1'b0, 1'b1, 8'h3C);
        chk(rd_cnt == r0 + 1, "R8", "single strobe on long read", rd_cnt - r0, 1);
        xfer(mk_cmd(1'b1, 9, 1'b0), 8'h00, 24, 1'b1, 1'b1, 8'h3C);

        // aborted read then fresh write: count restarts on chip select (R8)
        xfer(mk_cmd(1'b1, 40, 1'b0), 8'h00, 10, 1'b0, 1'b0, 8'h00);
        w0 = wr_cnt;
        xfer(mk_cmd(1'b0, 2, 1'b0), 8'h96, 16, 1'b1, 1'b0, 8'h00);
        exp_mem[2] = 8'h96;
        chk(wr_cnt == w0 + 1 && wr_addr_l == 2, "R8", "write after aborted read addr",
            wr_addr_l, 2);
        chk(wr_data_l == 8'h96, "R8", "write after aborted read data", wr_data_l, 8'h96);
        xfer(mk_cmd(1'b1, 2, 1'b0), 8'h00, 16, 1'b0, 1'b1, 8'h96);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule